// File: doc/BRIEF.md
# Host Controller Interrupt Enable Mask and List Pointer Registers

This block keeps the interrupt enable word of a host controller and turns it into one interrupt line. Software reaches the enable word through two addresses. At one address a write sets the enable bits given as ones in the write data. At the other address a write clears the enable bits given as ones. Zeros in the write data leave the matching bits unchanged at both addresses. Both addresses read back the same word. Bit 31 is a master gate. The interrupt line rises when the master gate is on and at least one event has both its raw status bit and its enable bit set.

The same register port also holds five list pointer registers. Each pointer keeps only its aligned high bits. The low bits are forced to zero whenever the pointer is written or read. The register port is synchronous, with an address, a write strobe, write data and combinational read data. The raw event status comes from outside the block.

Top module: `hc_irq_mask_bank`

## Requirements
- R1: A write to address 10h sets each implemented enable bit whose write data bit is 1. Bits written as 0 keep their value. The change is visible on the next read after the write clock edge.
- R2: A write to address 14h clears each enable bit whose write data bit is 1. Bits written as 0 keep their value.
- R3: Reads at address 10h and at address 14h both return the current enable word.
- R4: Enable bit 4 and enable bits 29:7 are not implemented. Writes cannot set them, they always read as 0, and status bit 4 never causes an interrupt.
- R5: Each enable bit gates only its own event: bit 0 scheduling overrun, bit 1 list writeback done, bit 2 frame start, bit 3 resume detected, bit 5 frame counter overflow, bit 6 port status change, bit 30 ownership change.
- R6: While master bit 31 of the enable word is 0, the interrupt output stays low whatever the status and the per-event bits are.
- R7: The interrupt output is registered. After a clock edge it equals (master bit) AND (OR over the events of status AND enable), using the values from before that edge. It therefore follows a change of mask or status one clock later.
- R8: After reset, the enable word, all pointers and the interrupt output are zero.
- R9: The communication area base pointer at 18h stores bits 31:8. Bits 7:0 read as zero.
- R10: The four list pointers at 1Ch, 20h, 24h and 28h store bits 31:4. Bits 3:0 read as zero.
- R11: A read of any other address, or of an address with bits 1:0 not zero, returns 0. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 8 | Byte address of the register access |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| eventStatus | input | 32 | Raw event status bits, at the same positions as the enable bits |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The hardest thing to show from the ports is R5: that each enable bit is routed to its own event and to no other. An OR over all events hides a crossed wire whenever several events are active together. The stimulus therefore walks every event position in turn. For each one it enables only that event and the master bit, and first presents every other event status bit, expecting the line to stay low. It then presents only the matching bit and expects the line to rise exactly one clock later. Separate steps drive status bit 4, and write all ones to both aliases, to confirm that the unimplemented bits never latch.

// File: rtl/hc_irq_mask_pkg.sv
package hc_irq_mask_pkg;

  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 8;
  localparam int NUM_LIST    = 4;
  localparam int BASE_ALIGN  = 8;
  localparam int LIST_ALIGN  = 4;
  localparam int MASTER_BIT  = 31;
  localparam int LIST_STRIDE = 4;
  localparam int LIST_IDX_W  = (NUM_LIST > 1) ? $clog2(NUM_LIST) : 1;

  localparam logic [ADDR_W-1:0] ADDR_SET   = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_CLR   = 8'h14;
  localparam logic [ADDR_W-1:0] ADDR_BASE  = 8'h18;
  localparam logic [ADDR_W-1:0] ADDR_LIST0 = 8'h1C;

  // per-event enable positions (bit 4 left out: not implemented)
  localparam logic [DATA_W-1:0] EVENT_BITS = 32'h4000_006F;
  localparam logic [DATA_W-1:0] MASTER_MSK = DATA_W'(1) << MASTER_BIT;
  localparam logic [DATA_W-1:0] IMPL_BITS  = EVENT_BITS | MASTER_MSK;

  localparam logic [DATA_W-1:0] BASE_KEEP = {DATA_W{1'b1}} << BASE_ALIGN;
  localparam logic [DATA_W-1:0] LIST_KEEP = {DATA_W{1'b1}} << LIST_ALIGN;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_MASK,
    RD_BASE,
    RD_LIST
  } rdSel_e;

  typedef struct packed {
    logic                  setMask;
    logic                  clrMask;
    logic                  wrBase;
    logic [NUM_LIST-1:0]   wrList;
    rdSel_e                rdSel;
    logic [LIST_IDX_W-1:0] rdIdx;
  } regStrobe_t;

endpackage

// File: rtl/hc_irq_mask_ctrl.sv
module hc_irq_mask_ctrl
  import hc_irq_mask_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobe
);

  logic              aligned;
  logic [NUM_LIST-1:0] listHit;

  assign aligned = (regAddr[1:0] == 2'b00);

  generate
    for (genvar gi = 0; gi < NUM_LIST; gi++) begin : g_listDec
      localparam logic [ADDR_W-1:0] LIST_ADDR = ADDR_W'(ADDR_LIST0 + gi * LIST_STRIDE);
      assign listHit[gi] = aligned && (regAddr == LIST_ADDR);
    end
  endgenerate

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_NONE;
    if (aligned && regAddr == ADDR_SET) begin
      strobe.rdSel   = RD_MASK;
      strobe.setMask = regWrEn;
    end else if (aligned && regAddr == ADDR_CLR) begin
      strobe.rdSel   = RD_MASK;
      strobe.clrMask = regWrEn;
    end else if (aligned && regAddr == ADDR_BASE) begin
      strobe.rdSel  = RD_BASE;
      strobe.wrBase = regWrEn;
    end else if (|listHit) begin
      strobe.rdSel  = RD_LIST;
      strobe.wrList = listHit & {NUM_LIST{regWrEn}};
      for (int i = 0; i < NUM_LIST; i++) begin
        if (listHit[i]) strobe.rdIdx = LIST_IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/hc_irq_mask_datapath.sv
module hc_irq_mask_datapath
  import hc_irq_mask_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] eventStatus,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] maskWord,
  output logic              irqOut
);

  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] maskNext;
  logic [DATA_W-1:0] setBits;
  logic [DATA_W-1:0] clrBits;
  logic [DATA_W-1:0] baseQ;
  logic [DATA_W-1:0] listQ [NUM_LIST];
  logic              irqQ;
  logic              irqNext;

  assign setBits  = strobe.setMask ? regWrData : '0;
  assign clrBits  = strobe.clrMask ? regWrData : '0;
  // clear takes priority over set on a shared bit
  assign maskNext = ((maskQ | setBits) & ~clrBits) & IMPL_BITS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '0;
    else       maskQ <= maskNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            baseQ <= '0;
    else if (strobe.wrBase) baseQ <= regWrData & BASE_KEEP;
  end

  generate
    for (genvar gi = 0; gi < NUM_LIST; gi++) begin : g_listReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 listQ[gi] <= '0;
        else if (strobe.wrList[gi]) listQ[gi] <= regWrData & LIST_KEEP;
      end
    end
  endgenerate

  assign irqNext = maskQ[MASTER_BIT] & (|(eventStatus & maskQ & EVENT_BITS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= irqNext;
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_MASK: regRdData = maskQ;
      RD_BASE: regRdData = baseQ;
      RD_LIST: regRdData = listQ[strobe.rdIdx];
      default: regRdData = '0;
    endcase
  end

  assign maskWord = maskQ;
  assign irqOut   = irqQ;

endmodule

// File: rtl/hc_irq_mask_bank.sv
module hc_irq_mask_bank
  import hc_irq_mask_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] eventStatus,
  output logic              irqOut
);

  regStrobe_t        strobe;
  logic [DATA_W-1:0] maskWord;

  hc_irq_mask_ctrl i_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  hc_irq_mask_datapath i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regWrData   (regWrData),
    .eventStatus (eventStatus),
    .regRdData   (regRdData),
    .maskWord    (maskWord),
    .irqOut      (irqOut)
  );

endmodule

// File: rtl/hc_irq_mask_checker.sv
module hc_irq_mask_checker
  import hc_irq_mask_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic [DATA_W-1:0] eventStatus,
  input logic [DATA_W-1:0] maskWord,
  input logic              irqOut
);

  p_set_bits_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_SET) |=>
      ((maskWord & $past(regWrData) & IMPL_BITS) == ($past(regWrData) & IMPL_BITS)));

  p_clr_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CLR) |=> ((maskWord & $past(regWrData)) == '0));

  p_alias_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_SET || regAddr == ADDR_CLR) |-> (regRdData == maskWord));

  p_unimpl_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (maskWord & ~IMPL_BITS) == '0);

  p_master_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !maskWord[MASTER_BIT] |=> !irqOut);

  p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(maskWord[MASTER_BIT] && ((eventStatus & maskWord & EVENT_BITS) != '0))));

  p_base_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_BASE) |-> (regRdData[BASE_ALIGN-1:0] == '0));

  p_list_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr >= ADDR_LIST0 && regAddr[1:0] == 2'b00) |-> (regRdData[LIST_ALIGN-1:0] == '0));

  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[1:0] != 2'b00) |-> (regRdData == '0));

  p_mask_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && (regAddr == ADDR_SET || regAddr == ADDR_CLR)) |=> $stable(maskWord));

endmodule

bind hc_irq_mask_bank hc_irq_mask_checker i_chk (.*);

// File: tb/test_hc_irq_mask_bank.sv
`timescale 1ns/1ps
module test_hc_irq_mask_bank;

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'h10, 32'hFFFF_FFFF, 8'h10, 32'hC000_006F, 8'd1},  // R1 + R4
    '{8'h14, 32'h0000_0004, 8'h14, 32'hC000_006B, 8'd2},  // R2
    '{8'h14, 32'h0000_0000, 8'h10, 32'hC000_006B, 8'd3},  // R2 zero write, R3 alias
    '{8'h14, 32'h8000_0000, 8'h14, 32'h4000_006B, 8'd2},  // R2 master clear
    '{8'h10, 32'h3FFF_FF90, 8'h10, 32'h4000_006B, 8'd4},  // R4 bit4/reserved ignored
    '{8'h18, 32'h1234_5678, 8'h18, 32'h1234_5600, 8'd9},  // R9
    '{8'h1C, 32'hAAAA_AAAF, 8'h1C, 32'hAAAA_AAA0, 8'd10}, // R10
    '{8'h20, 32'h1111_111F, 8'h20, 32'h1111_1110, 8'd10}, // R10
    '{8'h24, 32'h2222_222E, 8'h24, 32'h2222_2220, 8'd10}, // R10
    '{8'h28, 32'hFFFF_FFFF, 8'h28, 32'hFFFF_FFF0, 8'd10}, // R10
    '{8'h2C, 32'hFFFF_FFFF, 8'h2C, 32'h0000_0000, 8'd11}, // R11 unmapped
    '{8'h1D, 32'h5555_5555, 8'h1C, 32'hAAAA_AAA0, 8'd11}, // R11 misaligned write
    '{8'h12, 32'hFFFF_FFFF, 8'h10, 32'h4000_006B, 8'd11}, // R11 misaligned near mask
    '{8'h14, 32'hFFFF_FFFF, 8'h10, 32'h0000_0000, 8'd2}   // R2 clear all
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] eventStatus = '0;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hc_irq_mask_bank i_hc_irq_mask_bank (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .eventStatus(eventStatus), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int evPos [7] = '{0, 1, 2, 3, 5, 6, 30};

    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 irq", {31'b0, irqOut}, 32'h0);
    regRead(8'h10, rd); check("R8 mask", rd, 32'h0);
    regRead(8'h18, rd); check("R8 base", rd, 32'h0);
    regRead(8'h28, rd); check("R8 list", rd, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      regWrite(VECS[i].wa, VECS[i].wd);
      regRead(VECS[i].ra, rd);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
    end

    // R5 and R7: one event at a time with master on
    foreach (evPos[k]) begin
      logic [31:0] bitSel;
      bitSel = 32'h1 << evPos[k];
      regWrite(8'h14, 32'hFFFF_FFFF);
      regWrite(8'h10, 32'h8000_0000 | bitSel);
      eventStatus = 32'h4000_007F & ~bitSel;
      @(negedge clk); @(negedge clk);
      check($sformatf("R5 other events bit%0d", evPos[k]), {31'b0, irqOut}, 32'h0);
      eventStatus = bitSel;
      #1;
      check("R7 no early rise", {31'b0, irqOut}, 32'h0);
      @(negedge clk);
      check($sformatf("R5 own event bit%0d", evPos[k]), {31'b0, irqOut}, 32'h1);
    end

    // R7: mask clear drops irq one clock later
    regAddr = 8'h14; regWrEn = 1'b1; regWrData = 32'h4000_0000;
    @(negedge clk);
    regWrEn = 1'b0;
    check("R7 still high after clear edge", {31'b0, irqOut}, 32'h1);
    @(negedge clk);
    check("R7 low one clock later", {31'b0, irqOut}, 32'h0);

    // R6: master off, everything else on
    regWrite(8'h10, 32'hFFFF_FFFF);
    regWrite(8'h14, 32'h8000_0000);
    eventStatus = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk);
    check("R6 master off", {31'b0, irqOut}, 32'h0);

    // R4: status bit 4 alone cannot interrupt
    regWrite(8'h10, 32'h8000_0000);
    eventStatus = 32'h0000_0010;
    @(negedge clk); @(negedge clk);
    check("R4 bit4 status", {31'b0, irqOut}, 32'h0);
    regRead(8'h14, rd);
    check("R4 readback", rd, 32'hC000_006F);

    // R8: reset in mid-run
    rstN = 1'b0;
    #1;
    check("R8 async irq", {31'b0, irqOut}, 32'h0);
    regRead(8'h1C, rd); check("R8 async list", rd, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule